// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two table entries from memory, one after the other. A walk starts when the requester presents a virtual address and the byte address of the top-level directory while the walker is idle. The walker first reads the directory slot chosen by the top ten address bits. If that entry is present, it reads the second-level slot chosen by the next ten bits, inside the page that the directory entry points to. The result is the frame number of the second entry joined with the 12-bit page offset, or a fault code that says which of the two levels was missing.

Memory is reached through a single word-read port with a request/acknowledge handshake and any latency. The walker issues one read at a time and keeps it steady until it is acknowledged. Entries use bit 0 as the presence flag and bits 31:12 as the frame number. Bits 11:1 have no effect on the walk.

Top module: `pt_walker`

## Requirements
- R1: After synchronous reset, `walk_ready` is 1, `mem_req` is 0 and `done_valid` is 0.
- R2: `walk_ready` is 1 only while the walker is idle. `walk_valid` has no effect while `walk_ready` is 0, and a request held across a busy period is taken only once the walker is idle again.
- R3: In the cycle after a walk is accepted, `mem_req` is 1 and `mem_addr` equals `walk_root + 4*walk_vaddr[31:22]`.
- R4: While `mem_req` is 1 and `mem_ack` is 0, `mem_req` and `mem_addr` keep their values into the next cycle. A `mem_ack` that arrives while `mem_req` is 0 is ignored.
- R5: When the acknowledged directory entry has bit 0 clear, no second read is issued. In the next cycle `done_valid` is 1, `done_fault` is 1 and `done_paddr` is 0.
- R6: When the acknowledged directory entry has bit 0 set, `mem_req` stays 1 in the next cycle and `mem_addr` becomes `{entry[31:12], vaddr[21:12], 2'b00}`.
- R7: When the acknowledged second-level entry has bit 0 clear, in the next cycle `done_valid` is 1, `done_fault` is 2 and `done_paddr` is 0.
- R8: When the acknowledged second-level entry has bit 0 set, in the next cycle `done_valid` is 1, `done_fault` is 0 and `done_paddr` is `{entry[31:12], vaddr[11:0]}`. Entry bits 11:1 do not affect the result at either level.
- R9: `done_valid` is high for exactly one cycle. In the cycle after it, `walk_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_valid | input | 1 | A walk request is present |
| walk_ready | output | 1 | Walker is idle and takes a request this cycle |
| walk_vaddr | input | 32 | Virtual address to translate |
| walk_root | input | 32 | Byte address of the top-level directory |
| done_valid | output | 1 | One-cycle pulse: result is valid |
| done_paddr | output | 32 | Physical address (0 on fault) |
| done_fault | output | 2 | 0 none, 1 directory miss, 2 table miss |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ack | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 32 | Entry word returned by memory |

## Verification
Two events can fall in the same cycle. The first is the end of one walk, the `done_valid` pulse, while the next walk request is already waiting on `walk_valid`. The second is the directory acknowledge together with the launch of the second-level read, which is also the first cycle of that new request. The bench keeps `walk_valid` high through whole walks and answers some reads in the cycle the request first appears. Its behavioural model then expects acceptance exactly one cycle after the pulse, and an address change with no gap in `mem_req`. Acknowledges injected while no read is pending must leave every output of the model's prediction untouched.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

    localparam int VA_W        = 32;
    localparam int PAGE_BITS   = 12;
    localparam int ENTRY_W     = 32;
    localparam int ENTRY_SHIFT = 2;
    localparam int IDX_W       = PAGE_BITS - ENTRY_SHIFT;
    localparam int DIR_W       = VA_W - PAGE_BITS - IDX_W;
    localparam int FRAME_W     = ENTRY_W - PAGE_BITS;
    localparam int PA_W        = FRAME_W + PAGE_BITS;
    localparam int ATTR_W      = PAGE_BITS - 1;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_DIR  = 2'd1,
        WS_TBL  = 2'd2,
        WS_DONE = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        WF_NONE = 2'd0,
        WF_DIR  = 2'd1,
        WF_TBL  = 2'd2
    } walk_fault_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [ATTR_W-1:0]  attrs;
        logic               present;
    } pt_entry_t;

    function automatic logic [VA_W-1:0] dir_slot(input logic [VA_W-1:0] root,
                                                 input logic [DIR_W-1:0] idx);
        logic [VA_W-1:0] step;
        step = VA_W'({idx, {ENTRY_SHIFT{1'b0}}});
        return root + step;
    endfunction

    function automatic logic [VA_W-1:0] tbl_slot(input logic [FRAME_W-1:0] frame,
                                                 input logic [IDX_W-1:0] idx);
        return {frame, idx, {ENTRY_SHIFT{1'b0}}};
    endfunction

    function automatic logic [PA_W-1:0] join_pa(input logic [FRAME_W-1:0] frame,
                                                input logic [PAGE_BITS-1:0] off);
        return {frame, off};
    endfunction

endpackage

// File: rtl/ptw_req_capture.sv
`timescale 1ns/1ps
module ptw_req_capture #(
    parameter int IDX_W     = ptw_pkg::IDX_W,
    parameter int PAGE_BITS = ptw_pkg::PAGE_BITS,
    localparam int LOW_W    = IDX_W + PAGE_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [LOW_W-1:0]     low_in,
    output logic [IDX_W-1:0]     tbl_idx,
    output logic [PAGE_BITS-1:0] page_off
);

    logic [LOW_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= '0;
        end else if (load) begin
            low_q <= low_in;
        end
    end

    assign tbl_idx  = low_q[LOW_W-1:PAGE_BITS];
    assign page_off = low_q[PAGE_BITS-1:0];

endmodule

// File: rtl/ptw_mem_port.sv
`timescale 1ns/1ps
module ptw_mem_port #(
    parameter int AW = ptw_pkg::VA_W,
    parameter int DW = ptw_pkg::ENTRY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          resp_valid,
    output logic [DW-1:0] resp_data
);

    logic          req_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            addr_q <= '0;
        end else if (issue) begin
            req_q  <= 1'b1;
            addr_q <= issue_addr;
        end else if (req_q && mem_ack) begin
            req_q  <= 1'b0;
        end
    end

    assign mem_req    = req_q;
    assign mem_addr   = addr_q;
    assign resp_valid = req_q && mem_ack;
    assign resp_data  = mem_rdata;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4

    AST_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
        (!mem_req && !issue) |=> !mem_req); // R4

endmodule

// File: rtl/ptw_walk_ctrl.sv
`timescale 1ns/1ps
module ptw_walk_ctrl
    import ptw_pkg::*;
#(
    parameter int AW    = VA_W,
    parameter int DW    = ENTRY_W,
    parameter int DIRW  = DIR_W,
    parameter int TIDXW = IDX_W,
    parameter int OFFW  = PAGE_BITS,
    parameter int PAW   = PA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             walk_valid,
    input  logic [DIRW-1:0]  dir_idx,
    input  logic [AW-1:0]    walk_root,
    input  logic [TIDXW-1:0] tbl_idx,
    input  logic [OFFW-1:0]  page_off,
    input  logic             resp_valid,
    input  logic [DW-1:0]    resp_data,
    output logic             walk_ready,
    output logic             load,
    output logic             issue,
    output logic [AW-1:0]    issue_addr,
    output logic             done_valid,
    output logic [PAW-1:0]   done_paddr,
    output walk_fault_e      done_fault
);

    walk_state_e    state_q, state_d;
    pt_entry_t      entry;
    logic           fin;
    walk_fault_e    fin_fault;
    logic [PAW-1:0] fin_pa;

    assign entry = pt_entry_t'(resp_data);

    always_comb begin
        state_d    = state_q;
        issue      = 1'b0;
        issue_addr = '0;
        fin        = 1'b0;
        fin_fault  = WF_NONE;
        fin_pa     = '0;
        case (state_q)
            WS_IDLE: begin
                if (walk_valid) begin
                    issue      = 1'b1;
                    issue_addr = dir_slot(walk_root, dir_idx);
                    state_d    = WS_DIR;
                end
            end
            WS_DIR: begin
                if (resp_valid) begin
                    if (entry.present) begin
                        issue      = 1'b1;
                        issue_addr = tbl_slot(entry.frame, tbl_idx);
                        state_d    = WS_TBL;
                    end else begin
                        fin       = 1'b1;
                        fin_fault = WF_DIR;
                        state_d   = WS_DONE;
                    end
                end
            end
            WS_TBL: begin
                if (resp_valid) begin
                    fin     = 1'b1;
                    state_d = WS_DONE;
                    if (entry.present) begin
                        fin_pa = join_pa(entry.frame, page_off);
                    end else begin
                        fin_fault = WF_TBL;
                    end
                end
            end
            default: begin
                state_d = WS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WS_IDLE;
            done_paddr <= '0;
            done_fault <= WF_NONE;
        end else begin
            state_q <= state_d;
            if (fin) begin
                done_paddr <= fin_pa;
                done_fault <= fin_fault;
            end
        end
    end

    assign walk_ready = (state_q == WS_IDLE);
    assign load       = walk_ready && walk_valid;
    assign done_valid = (state_q == WS_DONE);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (!done_valid && walk_ready)); // R9

    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault != WF_NONE) |-> (done_paddr == '0)); // R7

    AST_DIR_MISS_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_DIR && resp_valid && !entry.present) |=> (done_valid && done_fault == WF_DIR)); // R5

endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              walk_valid,
    output logic              walk_ready,
    input  logic [VA_W-1:0]   walk_vaddr,
    input  logic [VA_W-1:0]   walk_root,
    output logic              done_valid,
    output logic [PA_W-1:0]   done_paddr,
    output logic [1:0]        done_fault,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [ENTRY_W-1:0] mem_rdata
);

    localparam int LOW_W = IDX_W + PAGE_BITS;

    logic                 load;
    logic                 issue;
    logic [VA_W-1:0]      issue_addr;
    logic                 resp_valid;
    logic [ENTRY_W-1:0]   resp_data;
    logic [IDX_W-1:0]     tbl_idx;
    logic [PAGE_BITS-1:0] page_off;
    walk_fault_e          fault_code;

    ptw_req_capture #(
        .IDX_W     (IDX_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_capture (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .low_in   (walk_vaddr[LOW_W-1:0]),
        .tbl_idx  (tbl_idx),
        .page_off (page_off)
    );

    ptw_walk_ctrl #(
        .AW    (VA_W),
        .DW    (ENTRY_W),
        .DIRW  (DIR_W),
        .TIDXW (IDX_W),
        .OFFW  (PAGE_BITS),
        .PAW   (PA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .walk_valid (walk_valid),
        .dir_idx    (walk_vaddr[VA_W-1:LOW_W]),
        .walk_root  (walk_root),
        .tbl_idx    (tbl_idx),
        .page_off   (page_off),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .walk_ready (walk_ready),
        .load       (load),
        .issue      (issue),
        .issue_addr (issue_addr),
        .done_valid (done_valid),
        .done_paddr (done_paddr),
        .done_fault (fault_code)
    );

    ptw_mem_port #(
        .AW (VA_W),
        .DW (ENTRY_W)
    ) u_port (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .issue_addr (issue_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .resp_valid (resp_valid),
        .resp_data  (resp_data)
    );

    assign done_fault = fault_code;

    AST_READY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        walk_ready |-> (!mem_req && !done_valid)); // R2

    AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (rst)
        (walk_valid && walk_ready) |=> (mem_req && mem_addr == $past(walk_root) + {$past(walk_vaddr[31:22]), 2'b00})); // R3

    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_fault != 2'd3)); // R8

endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        walk_valid;
    logic        walk_ready;
    logic [31:0] walk_vaddr;
    logic [31:0] walk_root;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic [1:0]  done_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    always #10 clk = ~clk;

    pt_walker uut (
        .clk        (clk),
        .rst        (rst),
        .walk_valid (walk_valid),
        .walk_ready (walk_ready),
        .walk_vaddr (walk_vaddr),
        .walk_root  (walk_root),
        .done_valid (done_valid),
        .done_paddr (done_paddr),
        .done_fault (done_fault),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] mem [logic [31:0]];

    typedef struct {
        logic [31:0] va;
        logic [31:0] root;
    } walk_t;
    walk_t wq[$];

    // behavioural model: 0 idle, 1 directory read, 2 table read, 3 result
    int          m_state = 0;
    logic [31:0] m_va;
    logic [31:0] m_addr;
    logic [31:0] m_paddr;
    logic [1:0]  m_fault;
    int          ack_wait = -1;
    int          gap = 0;

    localparam logic [31:0] ROOT_A = 32'h0040_0000;
    localparam logic [31:0] ROOT_B = 32'h0080_1000;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] mk_va(input int d, input int t, input int o);
        return {d[9:0], t[9:0], o[11:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic compare();
        chk(walk_ready == (m_state == 0), "R2", "walk_ready", {31'b0, walk_ready}, {31'b0, m_state == 0});
        chk(mem_req == (m_state == 1 || m_state == 2), "R4", "mem_req", {31'b0, mem_req},
            {31'b0, (m_state == 1 || m_state == 2)});
        if (m_state == 1) chk(mem_addr == m_addr, "R3", "directory address", mem_addr, m_addr);
        if (m_state == 2) chk(mem_addr == m_addr, "R6", "table address", mem_addr, m_addr);
        chk(done_valid == (m_state == 3), "R9", "done_valid", {31'b0, done_valid}, {31'b0, m_state == 3});
        if (m_state == 3) begin
            if (m_fault == 2'd1) begin
                chk(done_fault == m_fault, "R5", "fault code", {30'b0, done_fault}, {30'b0, m_fault});
                chk(done_paddr == m_paddr, "R5", "paddr on dir fault", done_paddr, m_paddr);
            end else if (m_fault == 2'd2) begin
                chk(done_fault == m_fault, "R7", "fault code", {30'b0, done_fault}, {30'b0, m_fault});
                chk(done_paddr == m_paddr, "R7", "paddr on table fault", done_paddr, m_paddr);
            end else begin
                chk(done_fault == m_fault, "R8", "fault code", {30'b0, done_fault}, {30'b0, m_fault});
                chk(done_paddr == m_paddr, "R8", "translated paddr", done_paddr, m_paddr);
            end
        end
    endtask

    task automatic drive();
        if (gap > 0 || wq.size() == 0) begin
            walk_valid = 1'b0;
            walk_vaddr = $urandom;
            walk_root  = $urandom;
            if (gap > 0) gap--;
        end else begin
            walk_valid = 1'b1;
            walk_vaddr = wq[0].va;
            walk_root  = wq[0].root;
        end
        if (m_state == 1 || m_state == 2) begin
            if (ack_wait < 0) ack_wait = $urandom % 4;
            if (ack_wait == 0) begin
                mem_ack   = 1'b1;
                mem_rdata = rd(mem_addr);
                ack_wait  = -1;
            end else begin
                mem_ack   = 1'b0;
                mem_rdata = $urandom;
                ack_wait--;
            end
        end else begin
            // stray acknowledge with a present-looking word: must be ignored (R4)
            mem_ack   = (($urandom % 4) == 0);
            mem_rdata = 32'hFFFF_FFFF;
        end
    endtask

    task automatic model_step();
        logic [31:0] e;
        e = mem_rdata;
        case (m_state)
            0: if (walk_valid) begin
                m_va    = walk_vaddr;
                m_addr  = walk_root + {20'b0, walk_vaddr[31:22], 2'b00};
                m_state = 1;
                void'(wq.pop_front());
                gap = $urandom % 3;
            end
            1: if (mem_ack) begin
                if (e[0]) begin
                    m_addr  = {e[31:12], m_va[21:12], 2'b00};
                    m_state = 2;
                end else begin
                    m_fault = 2'd1;
                    m_paddr = 32'h0;
                    m_state = 3;
                end
            end
            2: if (mem_ack) begin
                if (e[0]) begin
                    m_fault = 2'd0;
                    m_paddr = {e[31:12], m_va[11:0]};
                end else begin
                    m_fault = 2'd2;
                    m_paddr = 32'h0;
                end
                m_state = 3;
            end
            default: m_state = 0;
        endcase
    endtask

    task automatic add_walk(input logic [31:0] root, input int d, input int t, input int o);
        walk_t w;
        w.va   = mk_va(d, t, o);
        w.root = root;
        wq.push_back(w);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // directory of ROOT_A: slot 0 present (attribute bits all set), 1023 present,
        // 5 absent with a nonzero frame, 7 never written
        mem[ROOT_A + 0 * 4]    = 32'h0010_0FFF;
        mem[ROOT_A + 1023 * 4] = 32'h0020_0001;
        mem[ROOT_A + 5 * 4]    = 32'h0030_0FFE;
        mem[ROOT_B + 2 * 4]    = 32'h0010_0001;
        // second-level table at frame 0x00100
        mem[32'h0010_0000 + 0 * 4]    = 32'hABCD_E001;
        mem[32'h0010_0000 + 1023 * 4] = 32'h1234_5FFF;
        mem[32'h0010_0000 + 9 * 4]    = 32'h5555_5000;
        // second-level table at frame 0x00200
        mem[32'h0020_0000 + 3 * 4]    = 32'hFFFF_F001;
        mem[32'h0020_0000 + 1023 * 4] = 32'h0000_0001;

        add_walk(ROOT_A, 0, 0, 12'h123);      // R8 plain hit
        add_walk(ROOT_A, 0, 1023, 12'hFFF);   // R8 top slot, full offset, attr bits set
        add_walk(ROOT_A, 0, 9, 0);            // R7 table miss
        add_walk(ROOT_A, 5, 4, 12'h010);      // R5 absent dir with frame bits
        add_walk(ROOT_A, 7, 0, 0);            // R5 empty dir slot
        add_walk(ROOT_A, 1023, 3, 0);         // R8 top dir slot, all-ones frame
        add_walk(ROOT_A, 1023, 1023, 12'hABC);// R8 frame zero
        add_walk(ROOT_B, 2, 0, 12'h456);      // R3 second root
        add_walk(ROOT_B, 0, 0, 0);            // R5 miss under second root
        for (int i = 0; i < 200; i++) begin
            int pick;
            int d;
            pick = $urandom % 5;
            d = (pick == 0) ? 0 : (pick == 1) ? 5 : (pick == 2) ? 7 : 1023;
            if (pick == 4) add_walk(ROOT_B, 2, ($urandom % 2) ? 0 : 1023, $urandom % 4096);
            else add_walk(ROOT_A, d, ($urandom % 2) ? ($urandom % 1024) : (d == 0 ? 0 : 3), $urandom % 4096);
        end

        rst        = 1'b1;
        walk_valid = 1'b0;
        walk_vaddr = 32'h0;
        walk_root  = 32'h0;
        mem_ack    = 1'b0;
        mem_rdata  = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(walk_ready == 1'b1, "R1", "walk_ready after reset", {31'b0, walk_ready}, 32'd1);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", {31'b0, mem_req}, 32'd0);
        chk(done_valid == 1'b0, "R1", "done_valid after reset", {31'b0, done_valid}, 32'd0);
        drive();
        model_step();
        while (wq.size() > 0 || m_state != 0) begin
            @(negedge clk);
            compare();
            drive();
            model_step();
        end
        repeat (4) begin
            @(negedge clk);
            compare();
            drive();
            model_step();
        end
        finish_run();
    end

endmodule